// File: doc/BRIEF.md
# Nibble-RAM Call/Return Stack Controller

This block manages the subroutine and interrupt return stack of a small 4-bit controller. The stack has no storage of its own. It uses a 64-nibble window of data RAM at addresses 0x3C0 to 0x3FF and reaches it through a nibble-wide RAM port. Each stack level packs a 14-bit program counter, a status bit and a carry bit into four consecutive nibbles. The stack grows toward lower addresses.

The core asks for a push on a call or on interrupt entry. It asks for a plain return or an interrupt return when leaving. The block performs four sequential nibble accesses and holds `busy` for the whole sequence. When a pop completes, it presents the recovered values together with load strobes. A plain return hands back only the program counter. An interrupt return also hands back status and carry. A push on a full stack, or a pop on an empty one, is refused with a one-cycle error pulse. A reset strobe empties the stack at once.

Top module: `nib_call_stack`

## Requirements
- R1: After reset, `stackLevel` is 0, and `busy`, `errFlag`, `ramWe`, `ramRe`, `pcLoad` and `flagLoad` are all 0.
- R2: An accepted push writes four nibbles in four consecutive cycles, at ascending addresses. Offset 0 holds {status, carry, PC13, PC12} with status in bit 3. Offset 1 holds PC11..PC8, offset 2 holds PC7..PC4 and offset 3 holds PC3..PC0.
- R3: Level n (1..16) occupies the addresses 0x400-4n to 0x403-4n. Level 1 is therefore at 0x3FC..0x3FF and level 16 at 0x3C0..0x3C3.
- R4: An accepted request raises `busy` in the cycle after the request edge. `busy` stays high for exactly four cycles, with `ramWe` (push) or `ramRe` (pop) high in each of them. `stackLevel` changes by one when `busy` falls.
- R5: A plain return (`retReq`) reloads `pcOut` from the top level and pulses `pcLoad` for one cycle in the cycle after `busy` falls. `stOut`, `caOut` and `flagLoad` stay unchanged.
- R6: An interrupt return (`retiReq`) also reloads `stOut` and `caOut` from the top level, and pulses `flagLoad` together with `pcLoad`.
- R7: A push request at level 16 pulses `errFlag` for one cycle. It writes no RAM, does not raise `busy` and leaves `stackLevel` at 16.
- R8: A return request at level 0 pulses `errFlag` for one cycle. It reads no RAM, gives no `pcLoad` and leaves `stackLevel` at 0.
- R9: `spReset` takes priority over everything else. It sets `stackLevel` to 0 and ends any sequence in progress on the next edge.
- R10: Requests that arrive while `busy` is high are ignored. When requests arrive together while idle, push wins over interrupt return, and interrupt return wins over plain return.
- R11: Pops return the pushed entries in last-in first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pushReq | input | 1 | Push request (call or interrupt entry) |
| retReq | input | 1 | Plain return request |
| retiReq | input | 1 | Interrupt return request |
| spReset | input | 1 | Empty the stack |
| pcIn | input | 14 | Program counter to push |
| stIn | input | 1 | Status bit to push |
| caIn | input | 1 | Carry bit to push |
| ramRdData | input | 4 | RAM read data, valid in the same cycle as `ramAddr` |
| ramAddr | output | 10 | RAM nibble address |
| ramWrData | output | 4 | RAM write data |
| ramWe | output | 1 | RAM write enable |
| ramRe | output | 1 | RAM read enable |
| busy | output | 1 | Sequence in progress |
| errFlag | output | 1 | One-cycle pulse when a push on full or a pop on empty is refused |
| stackLevel | output | 5 | Number of occupied levels (0..16) |
| pcOut | output | 14 | Restored program counter |
| stOut | output | 1 | Restored status bit |
| caOut | output | 1 | Restored carry bit |
| pcLoad | output | 1 | One-cycle strobe: `pcOut` has been updated |
| flagLoad | output | 1 | One-cycle strobe: `stOut` and `caOut` have been updated |

## Verification
The assertions assume that the RAM answers a read combinationally in the same cycle and that nothing other than this block writes the stack window. The bench's RAM model meets both conditions. They also assume that requests are held high for a single cycle. The stimulus drives every request for exactly one cycle on the falling edge and waits for `busy` to drop before issuing the next one. The only exceptions are the deliberate overlap and reset-abort cases, which check that such requests are ignored or take priority as specified.

// File: rtl/nib_stack_pkg.sv
package nib_stack_pkg;

  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_RET  = 2'd1,
    OP_RETI = 2'd2
  } stackOp_e;

  // strobes from the sequencer to the nibble datapath
  typedef struct packed {
    logic       latchIn;    // capture pc/status/carry for a push
    logic       writeNib;   // drive the current nibble onto the write bus
    logic       readNib;    // capture the current nibble from RAM
    logic       finish;     // last nibble of a pop: update outputs
    logic       withFlags;  // pop also restores status and carry
    logic [1:0] step;       // nibble index within the level
  } dpCtl_t;

endpackage

// File: rtl/nib_stack_ctrl.sv
module nib_stack_ctrl
  import nib_stack_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE = 10'h3C0,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushReq,
  input  logic              retReq,
  input  logic              retiReq,
  input  logic              spReset,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramWe,
  output logic              ramRe,
  output logic              busy,
  output logic              errFlag,
  output logic [LVL_W-1:0]  stackLevel,
  output dpCtl_t            dpCtl
);

  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic             busyQ;
  logic [1:0]       stepQ;
  stackOp_e         opQ;
  logic [LVL_W-1:0] levelQ;
  logic             errQ;

  logic             isFull, isEmpty, anyPop;
  logic [LVL_W-1:0] tgtLvl;
  logic [ADDR_W-1:0] slotIdx;

  assign isFull  = (levelQ == FULL);
  assign isEmpty = (levelQ == '0);
  assign anyPop  = retReq | retiReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      stepQ  <= 2'd0;
      opQ    <= OP_PUSH;
      levelQ <= '0;
      errQ   <= 1'b0;
    end else begin
      errQ <= 1'b0;
      if (spReset) begin
        busyQ  <= 1'b0;
        stepQ  <= 2'd0;
        levelQ <= '0;
      end else if (!busyQ) begin
        if (pushReq) begin
          if (isFull) errQ <= 1'b1;
          else begin
            busyQ <= 1'b1;
            opQ   <= OP_PUSH;
            stepQ <= 2'd0;
          end
        end else if (anyPop) begin
          if (isEmpty) errQ <= 1'b1;
          else begin
            busyQ <= 1'b1;
            opQ   <= retiReq ? OP_RETI : OP_RET;
            stepQ <= 2'd0;
          end
        end
      end else begin
        stepQ <= stepQ + 2'd1;
        if (stepQ == 2'd3) begin
          busyQ  <= 1'b0;
          levelQ <= (opQ == OP_PUSH) ? levelQ + 1'b1 : levelQ - 1'b1;
        end
      end
    end
  end

  // a push targets the level above the current top, a pop the top itself
  always_comb begin
    tgtLvl  = (opQ == OP_PUSH) ? levelQ + 1'b1 : levelQ;
    slotIdx = ADDR_W'(DEPTH) - ADDR_W'(tgtLvl);
    ramAddr = BASE + (slotIdx << 2) + ADDR_W'(stepQ);
  end

  assign ramWe      = busyQ && (opQ == OP_PUSH);
  assign ramRe      = busyQ && (opQ != OP_PUSH);
  assign busy       = busyQ;
  assign errFlag    = errQ;
  assign stackLevel = levelQ;

  always_comb begin
    dpCtl.latchIn   = !busyQ && !spReset && pushReq && !isFull;
    dpCtl.writeNib  = ramWe;
    dpCtl.readNib   = ramRe;
    dpCtl.finish    = ramRe && (stepQ == 2'd3) && !spReset;
    dpCtl.withFlags = (opQ == OP_RETI);
    dpCtl.step      = stepQ;
  end

  // R4: RAM is only touched while a sequence runs
  a_r4_ram_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe || ramRe) |-> busy);
  // R3: every access lands inside the stack window
  a_r3_addr_window: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe || ramRe) |-> (ramAddr >= BASE && ramAddr <= BASE + ADDR_W'(4*DEPTH-1)));
  // R4: the level does not move in the middle of a sequence
  a_r4_level_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !spReset) |=> ($stable(stackLevel) || !busy));
  // R7: a push on a full stack is refused
  a_r7_full_push_err: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !spReset && pushReq && stackLevel == FULL) |=>
      (errFlag && !busy && stackLevel == FULL));
  // R8: a pop on an empty stack is refused
  a_r8_empty_pop_err: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !spReset && !pushReq && anyPop && stackLevel == '0) |=>
      (errFlag && !busy && !ramRe && stackLevel == '0));
  // R9: the reset strobe empties the stack
  a_r9_sp_reset: assert property (@(posedge clk) disable iff (!rstN)
    spReset |=> (stackLevel == '0 && !busy));
  // R7: the level never exceeds the depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    stackLevel <= FULL);

endmodule

// File: rtl/nib_stack_dp.sv
module nib_stack_dp
  import nib_stack_pkg::*;
#(
  parameter int PC_W = 14,
  localparam int WORD_W = PC_W + 2,
  localparam int NIBS = WORD_W / 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpCtl_t          dpCtl,
  input  logic [PC_W-1:0] pcIn,
  input  logic            stIn,
  input  logic            caIn,
  input  logic [3:0]      ramRdData,
  output logic [3:0]      ramWrData,
  output logic [PC_W-1:0] pcOut,
  output logic            stOut,
  output logic            caOut,
  output logic            pcLoad,
  output logic            flagLoad
);

  // word layout: {status, carry, pc}; nibble k (lowest address first) is the
  // k-th nibble counted from the most significant end
  logic [WORD_W-1:0] wordQ;
  logic [WORD_W-1:0] assembled;

  always_comb begin
    assembled = wordQ;
    assembled[(NIBS-1-int'(dpCtl.step))*4 +: 4] = ramRdData;
  end

  assign ramWrData = wordQ[(NIBS-1-int'(dpCtl.step))*4 +: 4];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ    <= '0;
      pcOut    <= '0;
      stOut    <= 1'b0;
      caOut    <= 1'b0;
      pcLoad   <= 1'b0;
      flagLoad <= 1'b0;
    end else begin
      pcLoad   <= dpCtl.finish;
      flagLoad <= dpCtl.finish && dpCtl.withFlags;
      if (dpCtl.latchIn) wordQ <= {stIn, caIn, pcIn};
      else if (dpCtl.readNib) wordQ <= assembled;
      if (dpCtl.finish) begin
        pcOut <= assembled[PC_W-1:0];
        if (dpCtl.withFlags) {stOut, caOut} <= assembled[WORD_W-1 -: 2];
      end
    end
  end

  // R5: status and carry move only together with their load strobe
  a_r5_flags_only_on_load: assert property (@(posedge clk) disable iff (!rstN)
    !flagLoad |-> ($stable(stOut) && $stable(caOut)));
  // R6: a flag load always comes with a program counter load
  a_r6_flag_with_pc: assert property (@(posedge clk) disable iff (!rstN)
    flagLoad |-> pcLoad);
  // R5: the program counter output moves only on its load strobe
  a_r5_pc_only_on_load: assert property (@(posedge clk) disable iff (!rstN)
    !pcLoad |-> $stable(pcOut));

endmodule

// File: rtl/nib_call_stack.sv
module nib_call_stack
  import nib_stack_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE = 10'h3C0,
  parameter int PC_W = 14,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushReq,
  input  logic              retReq,
  input  logic              retiReq,
  input  logic              spReset,
  input  logic [PC_W-1:0]   pcIn,
  input  logic              stIn,
  input  logic              caIn,
  input  logic [3:0]        ramRdData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [3:0]        ramWrData,
  output logic              ramWe,
  output logic              ramRe,
  output logic              busy,
  output logic              errFlag,
  output logic [LVL_W-1:0]  stackLevel,
  output logic [PC_W-1:0]   pcOut,
  output logic              stOut,
  output logic              caOut,
  output logic              pcLoad,
  output logic              flagLoad
);

  dpCtl_t dpCtl;

  nib_stack_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .BASE(BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .retReq(retReq),
    .retiReq(retiReq), .spReset(spReset), .ramAddr(ramAddr), .ramWe(ramWe),
    .ramRe(ramRe), .busy(busy), .errFlag(errFlag), .stackLevel(stackLevel),
    .dpCtl(dpCtl)
  );

  nib_stack_dp #(.PC_W(PC_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .pcIn(pcIn), .stIn(stIn),
    .caIn(caIn), .ramRdData(ramRdData), .ramWrData(ramWrData),
    .pcOut(pcOut), .stOut(stOut), .caOut(caOut), .pcLoad(pcLoad),
    .flagLoad(flagLoad)
  );

  // R1/R4: a refused request never starts a sequence
  a_r4_err_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !busy);

endmodule

// File: tb/nib_call_stack_tb.sv
module nib_call_stack_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushReq = 0, retReq = 0, retiReq = 0, spReset = 0;
  logic [13:0] pcIn = '0;
  logic stIn = 0, caIn = 0;
  logic [3:0] ramRdData;
  logic [9:0] ramAddr;
  logic [3:0] ramWrData;
  logic ramWe, ramRe, busy, errFlag, stOut, caOut, pcLoad, flagLoad;
  logic [4:0] stackLevel;
  logic [13:0] pcOut;

  logic [3:0] mem [1024];
  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  logic [15:0] mStk [17];
  int mLvl = 0;
  logic mSt = 0, mCa = 0;
  logic [13:0] mPc = '0;

  always #4 clk = ~clk;

  always @(posedge clk) if (ramWe) mem[ramAddr] <= ramWrData;
  assign ramRdData = mem[ramAddr];

  nib_call_stack u_dut (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .retReq(retReq),
    .retiReq(retiReq), .spReset(spReset), .pcIn(pcIn), .stIn(stIn),
    .caIn(caIn), .ramRdData(ramRdData), .ramAddr(ramAddr),
    .ramWrData(ramWrData), .ramWe(ramWe), .ramRe(ramRe), .busy(busy),
    .errFlag(errFlag), .stackLevel(stackLevel), .pcOut(pcOut),
    .stOut(stOut), .caOut(caOut), .pcLoad(pcLoad), .flagLoad(flagLoad)
  );

  function automatic logic [9:0] slotAddr(int lvl, int k);
    return 10'(32'h400 - 4 * lvl + k);
  endfunction

  function automatic logic [3:0] nibOf(logic [15:0] w, int k);
    return w[(3 - k) * 4 +: 4];
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doPush(logic [13:0] pc, logic st, logic ca, int noiseAt, int abortAt);
    int weCnt = 0;
    logic [15:0] w = {st, ca, pc};
    bit aborted = 0;
    @(negedge clk);
    pushReq = 1; pcIn = pc; stIn = st; caIn = ca;
    @(negedge clk);
    pushReq = 0;
    if (mLvl == 16) begin
      check(errFlag == 1, "R7 err pulse", 32'(errFlag), 1);
      check(busy == 0 && ramWe == 0, "R7 no write", 32'(busy), 0);
      check(stackLevel == 16, "R7 level", 32'(stackLevel), 16);
      @(negedge clk);
      check(errFlag == 0, "R7 single pulse", 32'(errFlag), 0);
      return;
    end
    check(errFlag == 0, "R4 no err", 32'(errFlag), 0);
    for (int i = 0; i < 4; i++) begin
      if (ramWe && busy) weCnt++;
      if (busy) check(ramAddr == slotAddr(mLvl + 1, i), "R3 push addr",
                      32'(ramAddr), 32'(slotAddr(mLvl + 1, i)));
      if (i == noiseAt) begin retReq = 1; retiReq = 1; pushReq = 1; end
      if (i == abortAt) spReset = 1;
      @(negedge clk);
      retReq = 0; retiReq = 0; pushReq = 0;
      if (spReset) begin
        spReset = 0; aborted = 1;
        check(stackLevel == 0 && busy == 0, "R9 abort", 32'(stackLevel), 0);
        mLvl = 0;
        break;
      end
    end
    if (aborted) return;
    check(weCnt == 4, "R4 four writes", 32'(weCnt), 4);
    check(busy == 0, "R4 busy falls", 32'(busy), 0);
    mLvl++;
    mStk[mLvl] = w;
    check(stackLevel == 5'(mLvl), "R4 level up", 32'(stackLevel), 32'(mLvl));
    for (int k = 0; k < 4; k++)
      check(mem[slotAddr(mLvl, k)] == nibOf(w, k), "R2 nibble layout",
            32'(mem[slotAddr(mLvl, k)]), 32'(nibOf(w, k)));
    if (noiseAt >= 0) begin
      @(negedge clk);
      check(busy == 0 && pcLoad == 0 && stackLevel == 5'(mLvl), "R10 ignored",
            32'(stackLevel), 32'(mLvl));
    end
  endtask

  task automatic doPop(bit reti);
    int reCnt = 0;
    @(negedge clk);
    if (reti) retiReq = 1; else retReq = 1;
    @(negedge clk);
    retReq = 0; retiReq = 0;
    if (mLvl == 0) begin
      check(errFlag == 1, "R8 err pulse", 32'(errFlag), 1);
      check(busy == 0 && ramRe == 0, "R8 no read", 32'(busy), 0);
      @(negedge clk);
      check(pcLoad == 0 && stackLevel == 0, "R8 no load", 32'(pcLoad), 0);
      return;
    end
    for (int i = 0; i < 4; i++) begin
      if (ramRe && busy) reCnt++;
      @(negedge clk);
    end
    check(reCnt == 4, "R4 four reads", 32'(reCnt), 4);
    mPc = mStk[mLvl][13:0];
    if (reti) begin mSt = mStk[mLvl][15]; mCa = mStk[mLvl][14]; end
    mLvl--;
    check(pcLoad == 1, "R5 pcLoad pulse", 32'(pcLoad), 1);
    check(pcOut == mPc, "R11 lifo pc", 32'(pcOut), 32'(mPc));
    check(flagLoad == reti, reti ? "R6 flagLoad" : "R5 no flagLoad",
          32'(flagLoad), 32'(reti));
    check({stOut, caOut} == {mSt, mCa}, reti ? "R6 flags restored" : "R5 flags kept",
          32'({stOut, caOut}), 32'({mSt, mCa}));
    check(stackLevel == 5'(mLvl), "R4 level down", 32'(stackLevel), 32'(mLvl));
    @(negedge clk);
    check(pcLoad == 0, "R5 single pulse", 32'(pcLoad), 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(stackLevel == 0 && busy == 0 && errFlag == 0, "R1 reset state", 32'(stackLevel), 0);
    check(ramWe == 0 && ramRe == 0 && pcLoad == 0 && flagLoad == 0, "R1 reset strobes",
          32'({ramWe, ramRe, pcLoad, flagLoad}), 0);
    rstN = 1;
    // empty pop
    doPop(0);
    doPop(1);
    // level 1 at the top of the window
    doPush(14'h3ABC, 1, 0, -1, -1);
    check(mem[10'h3FC] == 4'hB && mem[10'h3FF] == 4'hC, "R3 level1 slot",
          32'(mem[10'h3FC]), 32'hB);
    doPop(1);
    // fill to the bottom
    for (int i = 0; i < 16; i++) doPush(14'(i * 777 + 5), i[0], i[1], -1, -1);
    check(mem[10'h3C3] == nibOf(mStk[16], 3), "R3 level16 slot",
          32'(mem[10'h3C3]), 32'(nibOf(mStk[16], 3)));
    doPush(14'h1111, 1, 1, -1, -1);   // overflow
    for (int i = 0; i < 16; i++) doPop(i[0]);
    doPop(0);                          // underflow
    // requests during busy are ignored
    doPush(14'h0F0F, 0, 1, 1, -1);
    // priority: push and reti together
    @(negedge clk);
    pushReq = 1; retiReq = 1; pcIn = 14'h2222; stIn = 1; caIn = 1;
    @(negedge clk);
    pushReq = 0; retiReq = 0;
    check(ramWe == 1 && ramRe == 0, "R10 push wins", 32'(ramWe), 1);
    repeat (4) @(negedge clk);
    mLvl++; mStk[mLvl] = {1'b1, 1'b1, 14'h2222};
    check(stackLevel == 5'(mLvl), "R10 level", 32'(stackLevel), 32'(mLvl));
    // priority: reti over ret
    @(negedge clk);
    retReq = 1; retiReq = 1;
    @(negedge clk);
    retReq = 0; retiReq = 0;
    repeat (4) @(negedge clk);
    mPc = 14'h2222; mSt = 1; mCa = 1; mLvl--;
    check(flagLoad == 1 && pcOut == mPc, "R10 reti wins", 32'(pcOut), 32'(mPc));
    // reset strobe mid-push
    doPush(14'h0123, 0, 0, -1, -1);
    doPush(14'h0456, 1, 0, -1, 2);
    check(stackLevel == 0, "R9 empty after reset", 32'(stackLevel), 0);
    doPop(0);
    // random mix
    for (int n = 0; n < 400; n++) begin
      int r = int'($urandom_range(0, 9));
      if (r < 5) doPush(14'($urandom), 1'($urandom), 1'($urandom), -1, -1);
      else if (r < 7) doPop(1);
      else doPop(0);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule